// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Alignment and Overlap Merge

This block is the digital back end of a pipelined analog-to-digital converter built from 1.5-bit stages. Each analog stage resolves one 2-bit decision per sample. Because the sample moves down the analog chain one half conversion period per stage, the decisions for a given sample arrive one tick apart. Stage 1 comes first, and the last stage comes ten ticks later. The block gives each stage a delay line sized so that all eleven decisions for a sample line up in the same cycle. It then merges them into one 12-bit word. Each stage's code is shifted by one bit less than the code before it, so adjacent codes share one bit, and the carries run upward through the sum.

The logic runs on a clock at twice the conversion rate, one tick per half period. Every stage input carries its own tag that says the code belongs to a real sample. A new sample may start every second tick, the normal rate, or on every tick. Each sample keeps its own slot in every delay line, so codes from different samples never mix. An illegal stage code is repaired before it is stored, and it also sets an error flag that stays set until reset.

Top module: `pipe_adc_align`

## Requirements
- R1: Stage k (k = 1..11) drives `stage_code[2k-1:2k-2]`. The output word is the sum over k of code_k × 2^(11−k), so stage 1 carries the largest weight and stage 11 the smallest.
- R2: The legal codes are 00, 01 and 10. Eleven stages all at 10 give 4094. All at 01 give 2047. All at 00 give 0.
- R3: For a sample whose stage 1 code is captured on tick T, stage k's code is captured on tick T+k−1. `out_vld` and `out_word` then show that sample in the cycle after clock edge T+11, which is one edge after stage 11's code is captured.
- R4: Samples that start every tick or every second tick each produce their own correct word, with no codes taken from a neighbouring sample.
- R5: `out_vld` is high for a sample only if all eleven stage tags were high when that sample's codes were captured. In every other cycle `out_vld` is low.
- R6: While `out_vld` is high, `out_word` never exceeds 4094.
- R7: A tagged stage code of 11 is merged as 10 and sets `code_err` after the capturing edge. `code_err` then stays high until reset. A code of 11 whose tag is low leaves `code_err` unchanged.
- R8: With `rst` high at a clock edge, the next cycle shows `out_vld`=0, `out_word`=0 and `code_err`=0. Samples in flight are discarded, and no strobe appears until a sample that started after reset has fully resolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period tick clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_code | input | 22 | Packed 2-bit decisions, stage k on bits [2k-1:2k-2] |
| stage_vld | input | 11 | Per-stage sample tag, bit k-1 for stage k |
| out_word | output | 12 | Merged conversion result |
| out_vld | output | 1 | Strobe marking a fully resolved sample |
| code_err | output | 1 | Sticky flag for a tagged illegal code |

## Verification
A sample whose stage 1 code is driven for capture at edge T shows its merged word after edge T+11. The bench therefore compares `out_vld` and `out_word` twelve loop iterations after the start tick, at the falling edge, with the word predicted from that sample's stored codes. `code_err` is due right after the edge that captures a tagged 11, so the model updates its expected flag as it drives that tick and checks it at the next falling edge. After reset, the bench expects cleared outputs at the first falling edge and expects no strobe for any sample that started before reset.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;
    localparam int CODE_W = 2;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_TOP = 2'b10;
    localparam code_t CODE_BAD = 2'b11;

    typedef struct packed {
        logic  vld;
        code_t code;
    } tagged_code_t;
endpackage

// File: rtl/adc_code_sanitize.sv
module adc_code_sanitize
    import adc_align_pkg::*;
(
    input  code_t        raw_code,
    input  logic         raw_vld,
    output tagged_code_t clean,
    output logic         bad
);
    always_comb begin
        clean.vld  = raw_vld;
        clean.code = (raw_code == CODE_BAD) ? CODE_TOP : raw_code;
        bad        = raw_vld && (raw_code == CODE_BAD);
    end
endmodule

// File: rtl/adc_code_delay.sv
module adc_code_delay
    import adc_align_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  tagged_code_t din,
    output tagged_code_t dout
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_line
            tagged_code_t [DEPTH-1:0] tap_d, tap_q;

            always_comb begin
                tap_d[0] = din;
                for (int i = 1; i < DEPTH; i++) begin
                    tap_d[i] = tap_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    tap_q <= '0;
                end else begin
                    tap_q <= tap_d;
                end
            end

            assign dout = tap_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/adc_overlap_sum.sv
module adc_overlap_sum
    import adc_align_pkg::*;
#(
    parameter int NUM_STAGES = 11,
    localparam int OUT_W = NUM_STAGES + 1
) (
    input  logic [NUM_STAGES-1:0][CODE_W-1:0] codes,
    output logic [OUT_W-1:0]                  sum
);
    always_comb begin
        logic [OUT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            acc = acc + (OUT_W'(codes[i]) << (NUM_STAGES - 1 - i));
        end
        sum = acc;
    end
endmodule

// File: rtl/pipe_adc_align.sv
module pipe_adc_align
    import adc_align_pkg::*;
#(
    parameter int NUM_STAGES = 11,
    localparam int OUT_W = NUM_STAGES + 1,
    localparam int IN_W = NUM_STAGES * CODE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IN_W-1:0]       stage_code,
    input  logic [NUM_STAGES-1:0] stage_vld,
    output logic [OUT_W-1:0]      out_word,
    output logic                  out_vld,
    output logic                  code_err
);
    typedef struct packed {
        tagged_code_t [NUM_STAGES-1:0] cap;
        logic [OUT_W-1:0]              word;
        logic                          vld;
        logic                          err;
    } state_t;

    state_t st_d, st_q;

    tagged_code_t [NUM_STAGES-1:0]      clean;
    logic [NUM_STAGES-1:0]              bad;
    tagged_code_t [NUM_STAGES-1:0]      aligned;
    logic [NUM_STAGES-1:0][CODE_W-1:0]  al_code;
    logic [NUM_STAGES-1:0]              al_vld;
    logic [OUT_W-1:0]                   merged;

    generate
        for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
            adc_code_sanitize u_fix (
                .raw_code (stage_code[CODE_W*i +: CODE_W]),
                .raw_vld  (stage_vld[i]),
                .clean    (clean[i]),
                .bad      (bad[i])
            );

            adc_code_delay #(
                .DEPTH (NUM_STAGES - 1 - i)
            ) u_dly (
                .clk  (clk),
                .rst  (rst),
                .din  (st_q.cap[i]),
                .dout (aligned[i])
            );

            assign al_code[i] = aligned[i].code;
            assign al_vld[i]  = aligned[i].vld;
        end
    endgenerate

    adc_overlap_sum #(
        .NUM_STAGES (NUM_STAGES)
    ) u_sum (
        .codes (al_code),
        .sum   (merged)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cap  = clean;
        st_d.word = merged;
        st_d.vld  = &al_vld;
        st_d.err  = st_q.err | (|bad);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_word = st_q.word;
    assign out_vld  = st_q.vld;
    assign code_err = st_q.err;
endmodule

// File: rtl/adc_align_chk.sv
module adc_align_chk #(
    parameter int NUM_STAGES = 11,
    localparam int OUT_W = NUM_STAGES + 1,
    localparam int IN_W = NUM_STAGES * 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic [IN_W-1:0]       stage_code,
    input logic [NUM_STAGES-1:0] stage_vld,
    input logic [OUT_W-1:0]      out_word,
    input logic                  out_vld,
    input logic                  code_err
);
    localparam logic [OUT_W-1:0] WORD_CEIL = {{(OUT_W-1){1'b1}}, 1'b0};

    logic [NUM_STAGES-1:0] tag_bad;
    always_comb begin
        for (int i = 0; i < NUM_STAGES; i++) begin
            tag_bad[i] = stage_vld[i] && (stage_code[2*i +: 2] == 2'b11);
        end
    end

    // R6: merged word bounded one below all-ones
    a_r6_word_ceiling: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_word <= WORD_CEIL));

    // R7: tagged illegal code raises the flag after its capture edge
    a_r7_err_raise: assert property (@(posedge clk) disable iff (rst)
        (|tag_bad) |=> code_err);

    // R7: flag holds until reset
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        code_err |=> code_err);

    // R5: a strobe needs the last stage's tag two edges earlier
    a_r5_last_tag: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(stage_vld[NUM_STAGES-1], 2));

    // R8: reset clears every output
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_vld && !code_err && (out_word == '0)));
endmodule

bind pipe_adc_align adc_align_chk #(
    .NUM_STAGES (NUM_STAGES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stage_code (stage_code),
    .stage_vld  (stage_vld),
    .out_word   (out_word),
    .out_vld    (out_vld),
    .code_err   (code_err)
);

// File: tb/pipe_adc_align_test.sv
`timescale 1ns/1ps
module pipe_adc_align_test;
    localparam int N      = 11;
    localparam int OUT_W  = N + 1;
    localparam int MAXT   = 480;
    localparam int MAXS   = 300;
    localparam int LAT    = 12;
    localparam int RST_AT = 320;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2*N-1:0]    stage_code = '0;
    logic [N-1:0]      stage_vld  = '0;
    logic [OUT_W-1:0]  out_word;
    logic              out_vld;
    logic              code_err;

    always #2 clk = ~clk;

    pipe_adc_align uut (
        .clk        (clk),
        .rst        (rst),
        .stage_code (stage_code),
        .stage_vld  (stage_vld),
        .out_word   (out_word),
        .out_vld    (out_vld),
        .code_err   (code_err)
    );

    int             smap [MAXT];
    logic [2*N-1:0] scode [MAXS];
    int             sdrop [MAXS];
    string          sreq [MAXS];
    int             ns = 0;
    int             n_chk = 0;
    int             n_fail = 0;
    bit             err_state = 1'b0;
    bit             rst_prev = 1'b1;
    bit             done = 1'b0;

    task automatic add_sample(input int t, input logic [2*N-1:0] c, input int drop, input string req);
        smap[t]   = ns;
        scode[ns] = c;
        sdrop[ns] = drop;
        sreq[ns]  = req;
        ns++;
    endtask

    function automatic logic [2*N-1:0] rand_codes();
        logic [2*N-1:0] c;
        for (int k = 0; k < N; k++) c[2*k +: 2] = 2'($urandom % 3);
        return c;
    endfunction

    function automatic int exp_word(input int s);
        int acc = 0;
        for (int k = 0; k < N; k++) begin
            int c = int'(scode[s][2*k +: 2]);
            if (c == 3) c = 2;
            acc += c * (1 << (N - 1 - k));
        end
        return acc;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_tick(input int g);
        if (rst_prev) begin
            chk("R8 vld after reset", int'(out_vld), 0);
            chk("R8 word after reset", int'(out_word), 0);
            chk("R8 err after reset", int'(code_err), 0);
        end else begin
            int t = g - LAT;
            bit ev = 1'b0;
            int s = -1;
            if (t >= 0 && smap[t] >= 0) begin
                s  = smap[t];
                ev = (sdrop[s] < 0);
            end
            chk((s >= 0) ? {sreq[s], " R5 strobe"} : "R5 idle strobe", int'(out_vld), int'(ev));
            if (ev) chk({sreq[s], " R3 word"}, int'(out_word), exp_word(s));
            chk("R7 err flag", int'(code_err), int'(err_state));
        end
    endtask

    task automatic drive_tick(input int g);
        logic [2*N-1:0] c = '0;
        logic [N-1:0]   v = '0;
        for (int k = 0; k < N; k++) begin
            int t = g - k;
            if (t >= 0 && smap[t] >= 0) begin
                int s = smap[t];
                c[2*k +: 2] = scode[s][2*k +: 2];
                v[k] = (sdrop[s] != k);
                if (v[k] && c[2*k +: 2] == 2'b11) err_state = 1'b1;
            end else begin
                c[2*k +: 2] = 2'($urandom % 4);
            end
        end
        stage_code = c;
        stage_vld  = v;
    endtask

    initial begin
        #(4 * 4000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MAXT; i++) smap[i] = -1;

        add_sample(10, 22'h2AAAAA, -1, "R2 R6 all-10");
        add_sample(12, 22'h000000, -1, "R2 all-00");
        add_sample(14, 22'h155555, -1, "R2 all-01");
        for (int k = 0; k < N; k++) add_sample(16 + 2*k, 22'(2) << (2*k), -1, "R1 single-stage");
        add_sample(38, 22'h222222, -1, "R1 alternating");
        for (int i = 0; i < 40; i++) add_sample(40 + 2*i, rand_codes(), -1, "R4 every-2");
        for (int i = 0; i < 20; i++) add_sample(120 + i, rand_codes(), -1, "R4 every-tick");
        add_sample(150, rand_codes(), 5, "R5 dropped-tag");
        add_sample(152, rand_codes(), -1, "R5 after-drop");
        begin
            logic [2*N-1:0] c = rand_codes();
            c[9:8] = 2'b11;
            add_sample(200, c, -1, "R7 one-illegal");
        end
        add_sample(202, 22'h3FFFFF, -1, "R7 R6 all-illegal");
        for (int i = 0; i < 29; i++) add_sample(204 + 2*i, rand_codes(), -1, "R7 after-err");
        for (int i = 0; i < 4; i++) add_sample(310 + i, rand_codes(), -1, "R8 flushed");
        for (int i = 0; i < 20; i++) add_sample(330 + i, rand_codes(), -1, "R8 R4 post-reset");
        for (int i = 0; i < 25; i++) add_sample(350 + 2*i, rand_codes(), -1, "R8 post-reset");

        repeat (3) @(posedge clk);
        for (int g = 0; g < 420; g++) begin
            @(negedge clk);
            check_tick(g);
            if (g == RST_AT || g == RST_AT + 1) begin
                if (g == RST_AT) begin
                    for (int t = 0; t < RST_AT; t++) smap[t] = -1;
                    err_state = 1'b0;
                end
                rst        = 1'b1;
                stage_code = '0;
                stage_vld  = '0;
                rst_prev   = 1'b1;
            end else begin
                rst      = 1'b0;
                rst_prev = 1'b0;
                drive_tick(g);
            end
            if (g == 0) rst_prev = 1'b1;
            if (g == 0) rst_prev = 1'b0;
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule